// File: doc/BRIEF.md
# Microcontroller Reset Sequencer

This block decides when a small 4-bit microcontroller core may run. It combines three kinds of reset request into one reset sequence: the active-low external reset pin, a power-on-clear request, and fault requests raised by the core itself. The core can raise a fault for an illegal halt operand, for a rotate-left-zero executed with a zero accumulator, or for a stack pointer that overflows or underflows. While the pin is low, the block stops the oscillator and grounds its pins. Once every hold condition has cleared, it keeps the core in reset for a fixed stabilisation wait. After that wait the core starts fetching from address zero.

The block also supplies the values the core loads into its registers on reset, together with a one-cycle load strobe that fires at the start of each wait. Port P1 takes its low nibble from the key inputs at the moment of loading. A reset from the pin or from power-on-clear that arrives while the core is in standby skips the load, so the core keeps all of its register contents. A fault reset leaves the oscillator running and goes through the same wait.

Top module: `rstseq_top`

## Requirements
- R1: While `ext_rst_n` is low, `osc_en` is 0, `osc_gnd` is 1, `core_rst` is 1 and `reg_load` is 0, with no clock edge needed.
- R2: After `ext_rst_n` rises with `poc_req` low, `core_rst` first reads 0 after the (WAIT_CYC+3)th rising edge: two synchroniser edges, one edge to start the wait, then WAIT_CYC wait cycles with `osc_en` high.
- R3: If the pin goes low again during the wait, the wait is abandoned. The next release runs a full WAIT_CYC wait, and its load samples `key_in` afresh.
- R4: `rst_pin_pd` (a pull-down enable; the pin is never driven high) follows `poc_req`. One edge after `poc_req` is seen, the core is in reset with the oscillator stopped. After `poc_req` falls, `core_rst` first reads 0 after WAIT_CYC+1 edges.
- R5: Each reset that loads produces `reg_load` for exactly one cycle, at the start of its wait. The reset image is: `init_pc`=0, `init_sp`=0, `init_dp`=0, `init_stat`=0, `init_carry`=0, `init_tmr`=0, `init_p0`=FFh, `init_p3`=03h, `init_p4`=26h.
- R6: `init_p1` is {4'hF, key_in} with `key_in` sampled at the edge that raises `reg_load`. It holds that value until the next load.
- R7: A pin or power-on-clear reset entered while `in_standby` was high in the last running cycle does not pulse `reg_load` and leaves `init_p1` unchanged. The full wait still runs.
- R8: A one-cycle high on `flt_halt`, `flt_rlz` or `flt_stack` while the core runs raises `core_rst` two edges later, keeps `osc_en` high, loads, and runs the WAIT_CYC wait.
- R9: Fault inputs raised while `core_rst` is high are ignored: they cause no extra load and do not restart the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | External reset pin level, active low, asynchronous assert |
| poc_req | input | 1 | Power-on-clear request, active high, synchronous |
| in_standby | input | 1 | Core is in standby mode |
| flt_halt | input | 1 | Halt executed with illegal operand or unmet precondition |
| flt_rlz | input | 1 | Rotate-left-zero executed with zero accumulator |
| flt_stack | input | 1 | Stack pointer overflow or underflow |
| key_in | input | 4 | Key input levels sampled into P1 low nibble |
| osc_en | output | 1 | Oscillator enable |
| osc_gnd | output | 1 | Hold oscillator pins at ground |
| core_rst | output | 1 | Core reset, high while the core must not fetch |
| rst_pin_pd | output | 1 | Open-drain pull-down enable for the reset pin |
| reg_load | output | 1 | One-cycle strobe: load reset image into core registers |
| init_pc | output | 10 | Program counter reset value |
| init_sp | output | 1 | Stack pointer reset value |
| init_dp | output | 4 | Data pointer reset value |
| init_stat | output | 1 | Status flag reset value |
| init_carry | output | 1 | Carry flag reset value |
| init_tmr | output | 10 | Timer reset value |
| init_p0 | output | 8 | Port register P0 reset value |
| init_p1 | output | 8 | Port register P1 reset value |
| init_p3 | output | 8 | Control register P3 reset value |
| init_p4 | output | 8 | Control register P4 reset value |

## Verification
A wrong count in the wait counter shows as a `core_rst` fall at the wrong edge, so it is caught within one wait length of each release. A stale retention flag shows at once as a `reg_load` pulse that should be absent, or one that is missing, on the edge that starts the wait. It also leaves `init_p1` with a value other than expected. A fault path that is stuck or enabled at the wrong time shows within two edges, either as `core_rst` failing to rise or as an extra load while the core is already held in reset.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int PC_W    = 10;
    localparam int TMR_W   = 10;
    localparam int DP_W    = 4;
    localparam int PORT_W  = 8;
    localparam int KEY_W   = 4;
    localparam int N_FAULT = 3;

    localparam logic [PORT_W-1:0] P0_RST = 8'hFF;
    localparam logic [PORT_W-1:0] P3_RST = 8'h03;
    localparam logic [PORT_W-1:0] P4_RST = 8'h26;
    localparam logic [PORT_W-KEY_W-1:0] P1_HI_RST = 4'hF;

    typedef enum logic [1:0] {
        SQ_HOLD = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_RUN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic              sp;
        logic [DP_W-1:0]   dp;
        logic              stat;
        logic              carry;
        logic [TMR_W-1:0]  tmr;
        logic [PORT_W-1:0] p0;
        logic [PORT_W-1:0] p1;
        logic [PORT_W-1:0] p3;
        logic [PORT_W-1:0] p4;
    } core_image_t;

    // Register image loaded by the core; only P1's low nibble varies.
    function automatic core_image_t build_image(input logic [KEY_W-1:0] keys);
        core_image_t img;
        img.pc    = '0;
        img.sp    = 1'b0;
        img.dp    = '0;
        img.stat  = 1'b0;
        img.carry = 1'b0;
        img.tmr   = '0;
        img.p0    = P0_RST;
        img.p1    = {P1_HI_RST, keys};
        img.p3    = P3_RST;
        img.p4    = P4_RST;
        return img;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic released
);
    logic [STAGES-1:0] q;

    // Assert immediately, release after STAGES edges.
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) q[0] <= 1'b0;
                else         q[0] <= 1'b1;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) q[i] <= 1'b0;
                else         q[i] <= q[i-1];
            end
        end
    end

    assign released = q[STAGES-1];
endmodule

// File: rtl/rstseq_merge.sv
module rstseq_merge #(
    parameter int N_FLT = 3
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             pin_released,
    input  logic             poc,
    input  logic             running,
    input  logic [N_FLT-1:0] flt,
    output logic             hold,
    output logic             flt_hit
);
    logic hit_q;

    assign hold = !pin_released || poc;

    // One-cycle registered fault pulse, only while the core runs.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) hit_q <= 1'b0;
        else         hit_q <= running && !hit_q && !hold && (|flt);
    end

    assign flt_hit = hit_q;
endmodule

// File: rtl/rstseq_wait.sv
module rstseq_wait #(
    parameter int WAIT_CYC = 512
) (
    input  logic clk,
    input  logic arst_n,
    input  logic active,
    output logic done
);
    localparam int CW = $clog2(WAIT_CYC);
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)      cnt <= '0;
        else if (!active) cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

    assign done = active && (cnt == LAST);
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int WAIT_CYC    = 512,  // legal range 246..694
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              ext_rst_n,
    input  logic              poc_req,
    input  logic              in_standby,
    input  logic              flt_halt,
    input  logic              flt_rlz,
    input  logic              flt_stack,
    input  logic [KEY_W-1:0]  key_in,
    output logic              osc_en,
    output logic              osc_gnd,
    output logic              core_rst,
    output logic              rst_pin_pd,
    output logic              reg_load,
    output logic [PC_W-1:0]   init_pc,
    output logic              init_sp,
    output logic [DP_W-1:0]   init_dp,
    output logic              init_stat,
    output logic              init_carry,
    output logic [TMR_W-1:0]  init_tmr,
    output logic [PORT_W-1:0] init_p0,
    output logic [PORT_W-1:0] init_p1,
    output logic [PORT_W-1:0] init_p3,
    output logic [PORT_W-1:0] init_p4
);
    seq_state_e state, nxt;
    logic pin_rel, hold, flt_hit, wait_done, load_nxt, load_q;
    logic keep_q = 1'b0;
    logic [KEY_W-1:0] key_q = '0;
    core_image_t img;

    rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .arst_n(ext_rst_n), .released(pin_rel)
    );

    rstseq_merge #(.N_FLT(N_FAULT)) u_merge (
        .clk(clk), .arst_n(ext_rst_n), .pin_released(pin_rel),
        .poc(poc_req), .running(state == SQ_RUN),
        .flt({flt_stack, flt_rlz, flt_halt}),
        .hold(hold), .flt_hit(flt_hit)
    );

    rstseq_wait #(.WAIT_CYC(WAIT_CYC)) u_wait (
        .clk(clk), .arst_n(ext_rst_n), .active(state == SQ_WAIT),
        .done(wait_done)
    );

    always_comb begin
        nxt      = state;
        load_nxt = 1'b0;
        unique case (state)
            SQ_HOLD: if (!hold) begin
                nxt      = SQ_WAIT;
                load_nxt = !keep_q;
            end
            SQ_WAIT: begin
                if (hold)           nxt = SQ_HOLD;
                else if (wait_done) nxt = SQ_RUN;
            end
            SQ_RUN: begin
                if (hold) nxt = SQ_HOLD;
                else if (flt_hit) begin
                    nxt      = SQ_WAIT;
                    load_nxt = 1'b1;
                end
            end
            default: nxt = SQ_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n) begin
            state  <= SQ_HOLD;
            load_q <= 1'b0;
        end else begin
            state  <= nxt;
            load_q <= load_nxt;
        end
    end

    // Retention decision and key sample survive the pin reset.
    always_ff @(posedge clk) begin
        if (state == SQ_RUN) keep_q <= in_standby && !flt_hit;
        if (load_nxt)        key_q  <= key_in;
    end

    assign img        = build_image(key_q);
    assign osc_en     = ext_rst_n && (state != SQ_HOLD);
    assign osc_gnd    = !osc_en;
    assign core_rst   = !ext_rst_n || (state != SQ_RUN);
    assign rst_pin_pd = poc_req;
    assign reg_load   = load_q;
    assign init_pc    = img.pc;
    assign init_sp    = img.sp;
    assign init_dp    = img.dp;
    assign init_stat  = img.stat;
    assign init_carry = img.carry;
    assign init_tmr   = img.tmr;
    assign init_p0    = img.p0;
    assign init_p1    = img.p1;
    assign init_p3    = img.p3;
    assign init_p4    = img.p4;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
    parameter int WAIT_CYC = 512
) (
    input logic clk,
    input logic ext_rst_n,
    input logic poc_req,
    input logic flt_halt,
    input logic flt_rlz,
    input logic flt_stack,
    input logic osc_en,
    input logic osc_gnd,
    input logic core_rst,
    input logic reg_load
);
    logic [15:0] wcnt;

    // Length of the current wait phase, counted at the ports.
    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n)               wcnt <= '0;
        else if (!osc_en || !core_rst) wcnt <= '0;
        else                           wcnt <= wcnt + 16'd1;
    end

    a_r1_pin_low_stops: assert property (@(posedge clk)
        !ext_rst_n |-> (!osc_en && osc_gnd && core_rst && !reg_load));

    a_r2_wait_length: assert property (@(posedge clk) disable iff (!ext_rst_n)
        $fell(core_rst) |-> (32'(wcnt) == WAIT_CYC));

    a_r4_poc_holds: assert property (@(posedge clk) disable iff (!ext_rst_n)
        poc_req |=> (core_rst && !osc_en));

    a_r5_load_single: assert property (@(posedge clk) disable iff (!ext_rst_n)
        reg_load |=> !reg_load);

    a_r5_load_in_wait: assert property (@(posedge clk) disable iff (!ext_rst_n)
        reg_load |-> (core_rst && osc_en));

    a_r8_fault_reset: assert property (@(posedge clk) disable iff (!ext_rst_n || poc_req)
        (!core_rst && (flt_halt || flt_rlz || flt_stack)) |-> ##2 (core_rst && osc_en));
endmodule

bind rstseq_top rstseq_chk #(.WAIT_CYC(WAIT_CYC)) u_chk (
    .clk(clk), .ext_rst_n(ext_rst_n), .poc_req(poc_req),
    .flt_halt(flt_halt), .flt_rlz(flt_rlz), .flt_stack(flt_stack),
    .osc_en(osc_en), .osc_gnd(osc_gnd), .core_rst(core_rst), .reg_load(reg_load)
);

// File: tb/sim_rstseq_top.sv
module sim_rstseq_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 512;

    logic clk = 1'b0;
    logic ext_rst_n = 1'b0, poc_req = 1'b1, in_standby = 1'b0;
    logic flt_halt = 1'b0, flt_rlz = 1'b0, flt_stack = 1'b0;
    logic [3:0] key_in = 4'hA;
    logic osc_en, osc_gnd, core_rst, rst_pin_pd, reg_load;
    logic [9:0] init_pc, init_tmr;
    logic init_sp, init_stat, init_carry;
    logic [3:0] init_dp;
    logic [7:0] init_p0, init_p1, init_p3, init_p4;

    int nchk = 0, nerr = 0;

    typedef struct { int kind; int val; string req; } exp_t;  // kind 0 load, 1 start
    exp_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rstseq_top #(.WAIT_CYC(W)) u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_load(input int p1, input string req);
        exp_t e; e.kind = 0; e.val = p1; e.req = req; sbq.push_back(e);
    endtask

    task automatic push_start(input string req);
        exp_t e; e.kind = 1; e.val = W; e.req = req; sbq.push_back(e);
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_run();
        for (int i = 0; i < 3000 && core_rst; i++) @(negedge clk);
        tick(1);
    endtask

    task automatic measure(output int n);
        @(negedge clk);
        n = 0;
        while (core_rst && n < 5000) begin @(negedge clk); n++; end
        tick(1);
    endtask

    // Monitor: pops expected events as the design produces them.
    int wcnt = 0;
    bit prev_rst = 1'b1;
    always @(negedge clk) begin
        exp_t e;
        if (!osc_en) wcnt = 0;
        else if (core_rst) wcnt++;
        if (reg_load) begin
            if (sbq.size() == 0) chk(0, "R7 unexpected load", init_p1, 0);
            else begin
                e = sbq.pop_front();
                chk(e.kind == 0 && init_p1 == e.val[7:0], e.req, init_p1, e.val);
            end
        end
        if (prev_rst && !core_rst) begin
            if (sbq.size() == 0) chk(0, "R9 unexpected start", wcnt, 0);
            else begin
                e = sbq.pop_front();
                chk(e.kind == 1 && wcnt == e.val, e.req, wcnt, e.val);
            end
            wcnt = 0;
        end
        prev_rst = core_rst;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int n;
        tick(5);
        // R1 reset state with pin low
        chk(!osc_en && osc_gnd, "R1 osc stopped", osc_en, 0);
        chk(core_rst && !reg_load, "R1 core held", core_rst, 1);
        chk(rst_pin_pd, "R4 pull-down during poc", rst_pin_pd, 1);
        poc_req = 1'b0;
        tick(2);
        chk(!rst_pin_pd, "R4 pull-down released", rst_pin_pd, 0);

        // R2 pin release latency
        push_load(8'hFA, "R6 load after pin release");
        push_start("R2 wait length pin");
        ext_rst_n = 1'b1;
        measure(n);
        chk(n == W + 3, "R2 release latency", n, W + 3);
        chk(init_pc == 0 && init_tmr == 0 && init_dp == 0, "R5 pc/tmr/dp", init_pc, 0);
        chk(!init_sp && !init_stat && !init_carry, "R5 sp/flags", init_sp, 0);
        chk(init_p0 == 8'hFF, "R5 p0", init_p0, 8'hFF);
        chk(init_p3 == 8'h03, "R5 p3", init_p3, 8'h03);
        chk(init_p4 == 8'h26, "R5 p4", init_p4, 8'h26);
        chk(init_p1 == 8'hFA, "R6 p1", init_p1, 8'hFA);

        // R8 each fault source
        for (int f = 0; f < 3; f++) begin
            key_in = 4'(f + 1);
            push_load(8'hF0 | (f + 1), "R8 fault load");
            push_start("R8 fault wait");
            flt_halt = (f == 0); flt_rlz = (f == 1); flt_stack = (f == 2);
            tick(1);
            flt_halt = 0; flt_rlz = 0; flt_stack = 0;
            chk(!core_rst, "R8 not yet in reset", core_rst, 0);
            tick(1);
            chk(core_rst && osc_en, "R8 reset with osc on", {core_rst, osc_en}, 3);
            tick(100);
            chk(osc_en, "R8 osc stays on", osc_en, 1);
            wait_run();
        end

        // R9 faults during wait are ignored
        key_in = 4'h7;
        push_load(8'hF7, "R9 single load");
        push_start("R9 wait not restarted");
        flt_halt = 1; tick(1); flt_halt = 0;
        tick(20);
        flt_stack = 1; tick(1); flt_stack = 0;
        tick(50);
        flt_rlz = 1; tick(1); flt_rlz = 0;
        wait_run();

        // R3 reassert during wait
        key_in = 4'hA;
        push_load(8'hFA, "R3 first load");
        push_load(8'hF5, "R3 second load");
        push_start("R3 full wait after restart");
        ext_rst_n = 0; tick(3); ext_rst_n = 1;
        tick(100);
        ext_rst_n = 0; key_in = 4'h5; tick(3); ext_rst_n = 1;
        wait_run();

        // R7 retention on pin reset from standby
        in_standby = 1; key_in = 4'h3; tick(3);
        push_start("R7 pin standby wait");
        ext_rst_n = 0; tick(3); ext_rst_n = 1;
        wait_run();
        chk(init_p1 == 8'hF5, "R7 p1 retained pin", init_p1, 8'hF5);

        // R7 retention on poc from standby
        push_start("R7 poc standby wait");
        poc_req = 1; tick(4);
        chk(rst_pin_pd && !osc_en && core_rst, "R4 poc holds core", {rst_pin_pd, osc_en, core_rst}, 5);
        poc_req = 0;
        wait_run();
        chk(init_p1 == 8'hF5, "R7 p1 retained poc", init_p1, 8'hF5);

        // R4 normal poc latency
        in_standby = 0; key_in = 4'hC; tick(3);
        push_load(8'hFC, "R4 poc load");
        push_start("R4 poc wait");
        poc_req = 1; tick(4); poc_req = 0;
        measure(n);
        chk(n == W + 1, "R4 poc release latency", n, W + 1);

        tick(5);
        chk(sbq.size() == 0, "R5 all expected events seen", sbq.size(), 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule